// File: doc/BRIEF.md
# Tagged TDM Frame Serializer

This block is the codec-side transmitter for the serial data line that runs from a codec back to its link controller. Each frame it gathers up to twelve 20-bit parallel words, together with a per-slot valid request and a codec-ready flag. From these it builds a 16-bit tag slot and shifts out the tag followed by the twelve data slots, one bit per bit clock. The result is a 256-bit frame that lines up with the controller's frame sync.

Slot 1 carries the status address and slot 2 the status data for register reads. Line-1 ADC samples use slot 5, line-2 ADC samples slot 10, handset ADC samples slot 11, and I/O status slot 12. A slot whose valid request is low is sent as all zeros, whatever its data input holds. Inputs are captured once per frame, on the rising edge of sync, so upstream logic may update them freely while a frame is on the wire.

Top module: `tdm_tag_serializer`

## Requirements
- R1: After reset `sdo` is 0. After the last of the 256 bits of a frame, `sdo` stays 0 until the next rising edge of sync.
- R2: A frame starts on the first `bit_clk` rising edge that samples `sync_in` high after sampling it low. Frame bit 0 appears on `sdo` after that edge, and bit i appears i edges later. Holding sync high does not restart the frame.
- R3: Frame bit 0 (tag bit 15) is 1 when `codec_rdy` is high or at least one `slot_vld` bit is high. Otherwise it is 0.
- R4: Frame bits 1 to 12 (tag bits 14 down to 3) equal `slot_vld[0]` to `slot_vld[11]` in that order, where `slot_vld[k]` belongs to slot k+1.
- R5: Frame bits 13 to 15 (tag bits 2 to 0) are always 0.
- R6: Slot s (1 to 12) occupies frame bits 16+20(s-1) to 35+20(s-1), most significant bit first. Its data comes from `slot_data[20(s-1)+19 : 20(s-1)]`.
- R7: Every bit of a slot whose valid flag is 0 is sent as 0.
- R8: `slot_data`, `slot_vld` and `codec_rdy` are captured at the frame start edge. Changes made during the frame do not alter the frame being sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bit_clk | input | 1 | Serial bit clock; `sdo` changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_in | input | 1 | Frame sync from the controller, high for the tag phase |
| codec_rdy | input | 1 | Codec ready indication, ORed into tag bit 15 |
| slot_vld | input | 12 | Per-slot valid request, bit k for slot k+1 |
| slot_data | input | 240 | Twelve 20-bit slot words, slot 1 in the low bits |
| sdo | output | 1 | Serial frame output |

## Verification
The assertions assume that `sync_in` rises at most once every 256 bit clocks, so that each frame runs to completion. They also assume it stays high for no more than a frame length. The stimulus raises sync exactly once per frame, holds it for 16 clocks, and either starts the next frame on the edge right after the last bit or leaves a short idle gap first. The valid patterns, data words and the ready flag are drawn at random, mixed with the all-valid and none-valid corners, and they are rescrambled in mid-frame to test the capture rule.

// File: rtl/tdm_tag_serializer.sv
module tdm_tag_serializer #(
  parameter int SLOTS  = 12,
  parameter int SLOT_W = 20,
  parameter int TAG_W  = 16
) (
  input  logic                      bit_clk,
  input  logic                      rst_n,
  input  logic                      sync_in,
  input  logic                      codec_rdy,
  input  logic [SLOTS-1:0]          slot_vld,
  input  logic [SLOTS*SLOT_W-1:0]   slot_data,
  output logic                      sdo
);
  localparam int TB     = $clog2(TAG_W);
  localparam int SIB    = $clog2(SLOTS);
  localparam int SWB    = $clog2(SLOT_W);
  localparam int FRAME  = TAG_W + SLOTS * SLOT_W;
  localparam int FCW    = $clog2(FRAME + 1);

  logic              sync_q, busy, tag_ph, sdo_q;
  logic [TB-1:0]     tcnt;
  logic [SIB-1:0]    sidx;
  logic [SWB-1:0]    bidx;
  logic [SLOTS-1:0]  vld_lat;
  logic [SLOT_W-1:0] dat_lat [SLOTS];
  logic [TAG_W-1:0]  tag_now, tag_lat;

  wire start = sync_in & ~sync_q;

  always_comb begin
    tag_now = '0;
    tag_now[TAG_W-1] = codec_rdy | (|slot_vld);
    for (int k = 0; k < SLOTS; k++) tag_now[TAG_W-2-k] = slot_vld[k];
  end

  always_ff @(posedge bit_clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= 1'b0;
      busy    <= 1'b0;
      tag_ph  <= 1'b0;
      sdo_q   <= 1'b0;
      tcnt    <= '0;
      sidx    <= '0;
      bidx    <= '0;
      vld_lat <= '0;
      tag_lat <= '0;
      for (int k = 0; k < SLOTS; k++) dat_lat[k] <= '0;
    end else begin
      sync_q <= sync_in;
      if (start) begin
        tag_lat <= tag_now;
        vld_lat <= slot_vld;
        for (int k = 0; k < SLOTS; k++) dat_lat[k] <= slot_data[k*SLOT_W +: SLOT_W];
        busy    <= 1'b1;
        tag_ph  <= 1'b1;
        tcnt    <= TB'(TAG_W - 2);
        sdo_q   <= tag_now[TAG_W-1];
      end else if (busy && tag_ph) begin
        sdo_q <= tag_lat[tcnt];
        if (tcnt == '0) begin
          tag_ph <= 1'b0;
          sidx   <= '0;
          bidx   <= SWB'(SLOT_W - 1);
        end else begin
          tcnt <= tcnt - 1'b1;
        end
      end else if (busy) begin
        sdo_q <= vld_lat[sidx] & dat_lat[sidx][bidx];
        if (bidx == '0) begin
          if (sidx == SIB'(SLOTS - 1)) busy <= 1'b0;
          else begin
            sidx <= sidx + 1'b1;
            bidx <= SWB'(SLOT_W - 1);
          end
        end else begin
          bidx <= bidx - 1'b1;
        end
      end else begin
        sdo_q <= 1'b0;
      end
    end
  end

  assign sdo = sdo_q;

  logic [FCW-1:0] chk_cnt;
  always_ff @(posedge bit_clk or negedge rst_n) begin
    if (!rst_n)     chk_cnt <= '0;
    else if (start) chk_cnt <= FCW'(1);
    else if (busy)  chk_cnt <= chk_cnt + 1'b1;
  end

  // R1
  idle_low_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
    (!busy && !start) |=> !sdo);

  // R1
  frame_len_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
    $fell(busy) |-> chk_cnt == FCW'(FRAME));

  // R3
  tag_ready_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
    start |=> sdo == ($past(codec_rdy) | (|$past(slot_vld))));

  // R5
  tag_pad_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
    (!$stable(chk_cnt) && chk_cnt >= FCW'(SLOTS + 2) && chk_cnt <= FCW'(TAG_W)) |-> !sdo);

  // R7
  zero_fill_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
    (busy && !tag_ph && !start && !vld_lat[sidx]) |=> !sdo);
endmodule

// File: tb/tdm_tag_serializer_tb.sv
module tdm_tag_serializer_tb;
  logic         bit_clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         sync_in = 1'b0;
  logic         codec_rdy = 1'b0;
  logic [11:0]  slot_vld = '0;
  logic [239:0] slot_data = '0;
  logic         sdo;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4ns bit_clk = ~bit_clk;

  tdm_tag_serializer u_dut (
    .bit_clk(bit_clk), .rst_n(rst_n), .sync_in(sync_in), .codec_rdy(codec_rdy),
    .slot_vld(slot_vld), .slot_data(slot_data), .sdo(sdo)
  );

  function automatic logic [15:0] exp_tag(input logic rdy, input logic [11:0] v);
    logic [15:0] t = '0;
    t[15] = rdy | (|v);
    for (int k = 0; k < 12; k++) t[14-k] = v[k];
    return t;
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic scramble();
    codec_rdy = 1'($urandom);
    slot_vld  = 12'($urandom);
    for (int k = 0; k < 12; k++) slot_data[k*20 +: 20] = 20'($urandom);
  endtask

  task automatic run_frame(input logic rdy, input logic [11:0] v, input logic [239:0] d, input bit gap);
    logic [255:0] cap;
    logic [15:0]  t, et;
    logic [19:0]  got;
    if (gap) begin
      repeat (3) begin
        @(negedge bit_clk);
        check("R1 idle", 32'(sdo), 32'd0);
      end
    end
    codec_rdy = rdy; slot_vld = v; slot_data = d;
    sync_in = 1'b1;
    for (int i = 0; i < 256; i++) begin
      @(posedge bit_clk);
      @(negedge bit_clk);
      cap[i] = sdo;
      if (i == 15) sync_in = 1'b0;
      if (i == 100) scramble();
    end
    for (int i = 0; i < 16; i++) t[15-i] = cap[i];
    et = exp_tag(rdy, v);
    check("R3 tag15", 32'(t[15]), 32'(et[15]));
    check("R4 tag14..3", 32'(t[14:3]), 32'(et[14:3]));
    check("R5 tag2..0", 32'(t[2:0]), 32'd0);
    for (int s = 0; s < 12; s++) begin
      for (int j = 0; j < 20; j++) got[19-j] = cap[16 + 20*s + j];
      if (v[s]) check("R6 R8 slot data", 32'(got), 32'(d[s*20 +: 20]));
      else      check("R7 zero fill", 32'(got), 32'd0);
    end
  endtask

  initial begin
    logic [239:0] d;
    void'($urandom(32'd2468));
    repeat (3) @(negedge bit_clk);
    check("R1 reset", 32'(sdo), 32'd0);
    rst_n = 1'b1;
    @(negedge bit_clk);
    check("R1 after reset", 32'(sdo), 32'd0);
    for (int k = 0; k < 12; k++) d[k*20 +: 20] = 20'($urandom);
    run_frame(1'b0, 12'hFFF, d, 1'b1);
    run_frame(1'b0, 12'h000, d, 1'b0);
    run_frame(1'b1, 12'h000, d, 1'b1);
    run_frame(1'b0, 12'hA5A, {12{20'hFFFFF}}, 1'b0);
    run_frame(1'b0, 12'h001, {12{20'h80001}}, 1'b1);
    for (int f = 0; f < 10; f++) begin
      for (int k = 0; k < 12; k++) d[k*20 +: 20] = 20'($urandom);
      run_frame(1'($urandom), 12'($urandom), d, bit'(f % 2));
    end
    // R2: sync held high for many clocks must not restart the frame
    sync_in = 1'b1;
    for (int i = 0; i < 300; i++) begin
      @(posedge bit_clk);
      @(negedge bit_clk);
      if (i == 260) check("R2 no restart while high", 32'(sdo), 32'd0);
    end
    sync_in = 1'b0;
    repeat (4) @(negedge bit_clk);
    check("R1 idle end", 32'(sdo), 32'd0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge bit_clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule